// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. The transmit side takes a byte through a valid/ready handshake and sends it as a single frame on the line. The receive side watches the incoming line, rebuilds each character and presents it with a valid flag. It also keeps sticky parity, framing and overrun flags, which stay set until a clear pulse.

The frame shape comes from a few static inputs. It can carry 7 or 8 data bits, one of four parity options and one or two stop bits. The bit period is a whole number of core clocks, set by a separate divisor input. Both directions share the same format and divisor. These inputs are expected to stay stable while a frame is in flight.

Top module: `async_serial_xcvr`

## Requirements
- R1: After reset `serTx` is high, `txReady` is high, and `rxValid`, `errParity`, `errFrame` and `errOverrun` are low. `serTx` is high whenever `txReady` is high.
- R2: A transmitted frame is made of these bits, in this order, each lasting `cfgDivisor` clocks: one low start bit, the data bits least significant first, the parity bit if enabled, and then the high stop bits.
- R3: `cfgChar8`=1 sends 8 data bits and `cfgChar8`=0 sends 7. In 7-bit mode, bit 7 of `txData` has no effect on the line.
- R4: `cfgParity` selects the parity bit: 0 gives no parity bit; 1 gives even parity, where the parity bit makes the count of ones across the data bits and the parity bit even; 2 gives odd parity; 3 gives a parity bit that is always 0.
- R5: `cfgStop2`=1 sends two stop bits and 0 sends one. `txReady` stays low for exactly (1 + data bits + parity bits + stop bits) × `cfgDivisor` clocks after a byte is accepted.
- R6: A byte is accepted on a rising clock edge where `txValid` and `txReady` are both high.
- R7: The receiver starts a frame on a falling edge of `serRx` and re-checks the start bit at mid-bit. A low pulse shorter than half a bit is ignored. When the first stop bit is sampled, the character appears on `rxData` with `rxValid` high. `rxValid` stays high until `rxRead` is pulsed.
- R8: In 7-bit mode, bit 7 of `rxData` reads 0.
- R9: `errParity` is set when the received parity bit disagrees with the selected mode. In zero-parity mode, a received 1 counts as an error.
- R10: `errFrame` is set when the first stop bit is sampled low.
- R11: `errOverrun` is set when a new character completes while `rxValid` is still high and `rxRead` is low. The new character replaces the old one in `rxData`.
- R12: The three error flags are sticky. They stay set until a one-cycle `errClear` pulse.
- R13: `cfgDivisor` must be at least 4 clocks per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgChar8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfgParity | input | 2 | 0 none, 1 even, 2 odd, 3 always zero |
| cfgStop2 | input | 1 | 1 = two stop bits |
| cfgDivisor | input | DIV_W | Clocks per bit, at least 4 |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | Byte offered |
| txReady | output | 1 | Transmitter idle, byte can be accepted |
| serTx | output | 1 | Serial output line |
| serRx | input | 1 | Serial input line (asynchronous) |
| rxData | output | 8 | Last received character |
| rxValid | output | 1 | Unread character present |
| rxRead | input | 1 | Pulse that consumes the character |
| errParity | output | 1 | Sticky parity error |
| errFrame | output | 1 | Sticky framing error |
| errOverrun | output | 1 | Sticky overrun error |
| errClear | input | 1 | Pulse that clears all error flags |

## Verification
When the output is looped back to the input, it only ever carries well-formed frames, so the error paths cannot be reached that way. To reach them, the bench releases the loopback and drives `serRx` bit by bit. It builds frames with a wrong parity bit, with a 1 in zero-parity mode, and with a low stop bit. It also sends two characters back to back with no read between them. A one-cycle low pulse on an idle line exercises the mid-bit start re-check. A 7-bit frame followed by a high stop bit shows that a receiver taking 8 bits would have read a 1 in bit 7.

// File: rtl/sxcvr_pkg.sv
package sxcvr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_PAR   = 3'd3,
    PH_STOP  = 3'd4
  } phase_t;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_ZERO = 2'd3
  } parity_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   txLoad;
    logic   txShift;
    phase_t txPhase;
    logic   rxClear;
    logic   rxBit;
    logic   rxPar;
    logic   rxStop;
  } strobe_t;
endpackage

// File: rtl/sxcvr_ctrl.sv
module sxcvr_ctrl
  import sxcvr_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txValid,
  input  logic             cfgChar8,
  input  logic [1:0]       cfgParity,
  input  logic             cfgStop2,
  input  logic [DIV_W-1:0] cfgDivisor,
  input  logic             rxSync,
  output logic             txReady,
  output strobe_t          strobe
);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(4);

  logic [2:0] lastIdx;
  logic       parOn;
  assign lastIdx = cfgChar8 ? 3'd7 : 3'd6;
  assign parOn   = (cfgParity != 2'd0);

  // transmit sequencer
  phase_t           txState;
  logic [DIV_W-1:0] txCnt;
  logic [2:0]       txIdx;
  logic             txTick;
  assign txTick = (txCnt == cfgDivisor - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= PH_IDLE;
      txCnt   <= '0;
      txIdx   <= '0;
    end else if (txState == PH_IDLE) begin
      if (txValid) begin
        txState <= PH_START;
        txCnt   <= '0;
      end
    end else if (!txTick) begin
      txCnt <= txCnt + 1'b1;
    end else begin
      txCnt <= '0;
      case (txState)
        PH_START: begin
          txState <= PH_DATA;
          txIdx   <= '0;
        end
        PH_DATA: begin
          if (txIdx == lastIdx) begin
            txState <= parOn ? PH_PAR : PH_STOP;
            txIdx   <= '0;
          end else begin
            txIdx <= txIdx + 1'b1;
          end
        end
        PH_PAR: begin
          txState <= PH_STOP;
          txIdx   <= '0;
        end
        PH_STOP: begin
          if (cfgStop2 && txIdx == 3'd0) txIdx <= 3'd1;
          else txState <= PH_IDLE;
        end
        default: txState <= PH_IDLE;
      endcase
    end
  end

  // receive sequencer
  phase_t           rxState;
  logic [DIV_W-1:0] rxCnt;
  logic [2:0]       rxIdx;
  logic             rxPrev;
  logic             rxTick;
  logic             rxHalf;
  assign rxTick = (rxCnt == cfgDivisor - 1'b1);
  assign rxHalf = (rxCnt == (cfgDivisor >> 1) - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= PH_IDLE;
      rxCnt   <= '0;
      rxIdx   <= '0;
      rxPrev  <= 1'b1;
    end else begin
      rxPrev <= rxSync;
      case (rxState)
        PH_IDLE: begin
          if (rxPrev && !rxSync) begin
            rxState <= PH_START;
            rxCnt   <= '0;
          end
        end
        PH_START: begin
          if (rxHalf) begin
            rxCnt   <= '0;
            rxIdx   <= '0;
            rxState <= rxSync ? PH_IDLE : PH_DATA;
          end else begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
        PH_DATA: begin
          if (rxTick) begin
            rxCnt <= '0;
            if (rxIdx == lastIdx) rxState <= parOn ? PH_PAR : PH_STOP;
            else rxIdx <= rxIdx + 1'b1;
          end else begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
        PH_PAR: begin
          if (rxTick) begin
            rxCnt   <= '0;
            rxState <= PH_STOP;
          end else begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
        PH_STOP: begin
          if (rxTick) begin
            rxCnt   <= '0;
            rxState <= PH_IDLE;
          end else begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
        default: rxState <= PH_IDLE;
      endcase
    end
  end

  assign txReady = (txState == PH_IDLE);

  always_comb begin
    strobe.txLoad  = (txState == PH_IDLE) && txValid;
    strobe.txShift = (txState == PH_DATA) && txTick;
    strobe.txPhase = txState;
    strobe.rxClear = (rxState == PH_START) && rxHalf && !rxSync;
    strobe.rxBit   = (rxState == PH_DATA) && rxTick;
    strobe.rxPar   = (rxState == PH_PAR) && rxTick;
    strobe.rxStop  = (rxState == PH_STOP) && rxTick;
  end

  AST_DIV_MIN: assert property (@(posedge clk) disable iff (!rstN)
    cfgDivisor >= DIV_MIN); // R13
  AST_RX_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rxClear, strobe.rxBit, strobe.rxPar, strobe.rxStop})); // R7
  AST_TX_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txLoad |=> !txReady); // R6
endmodule

// File: rtl/sxcvr_dpath.sv
module sxcvr_dpath
  import sxcvr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CHAR_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              cfgChar8,
  input  logic [1:0]        cfgParity,
  input  logic [CHAR_W-1:0] txData,
  input  logic              serRx,
  input  logic              rxRead,
  input  logic              errClear,
  output logic              serTx,
  output logic              rxSync,
  output logic [CHAR_W-1:0] rxData,
  output logic              rxValid,
  output logic              errParity,
  output logic              errFrame,
  output logic              errOverrun
);
  parity_t parMode;
  assign parMode = parity_t'(cfgParity);

  // input synchronizer
  logic [SYNC_STAGES-1:0] syncQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else syncQ <= {syncQ[SYNC_STAGES-2:0], serRx};
  end
  assign rxSync = syncQ[SYNC_STAGES-1];

  // transmit shifter
  logic [CHAR_W-1:0] txMasked;
  logic [CHAR_W-1:0] txSh;
  logic              txOnes;
  assign txMasked = {txData[CHAR_W-1] & cfgChar8, txData[CHAR_W-2:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh   <= '0;
      txOnes <= 1'b0;
    end else if (strobe.txLoad) begin
      txSh   <= txMasked;
      txOnes <= ^txMasked;
    end else if (strobe.txShift) begin
      txSh <= txSh >> 1;
    end
  end

  always_comb begin
    case (strobe.txPhase)
      PH_START: serTx = 1'b0;
      PH_DATA:  serTx = txSh[0];
      PH_PAR: begin
        case (parMode)
          PAR_EVEN: serTx = txOnes;
          PAR_ODD:  serTx = ~txOnes;
          default:  serTx = 1'b0;
        endcase
      end
      default:  serTx = 1'b1;
    endcase
  end

  // receive shifter and status
  logic [CHAR_W-1:0] rxSh;
  logic              rxOnes;
  logic              rxParBad;
  logic              parBadNow;

  always_comb begin
    case (parMode)
      PAR_EVEN: parBadNow = rxOnes ^ rxSync;
      PAR_ODD:  parBadNow = ~(rxOnes ^ rxSync);
      PAR_ZERO: parBadNow = rxSync;
      default:  parBadNow = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh       <= '0;
      rxOnes     <= 1'b0;
      rxParBad   <= 1'b0;
      rxData     <= '0;
      rxValid    <= 1'b0;
      errParity  <= 1'b0;
      errFrame   <= 1'b0;
      errOverrun <= 1'b0;
    end else begin
      if (strobe.rxClear) begin
        rxSh     <= '0;
        rxOnes   <= 1'b0;
        rxParBad <= 1'b0;
      end
      if (strobe.rxBit) begin
        rxSh   <= {rxSync, rxSh[CHAR_W-1:1]};
        rxOnes <= rxOnes ^ rxSync;
      end
      if (strobe.rxPar) rxParBad <= parBadNow;

      if (strobe.rxStop) begin
        rxData  <= cfgChar8 ? rxSh : {1'b0, rxSh[CHAR_W-1:1]};
        rxValid <= 1'b1;
      end else if (rxRead) begin
        rxValid <= 1'b0;
      end

      if (strobe.rxStop && rxParBad) errParity <= 1'b1;
      else if (errClear) errParity <= 1'b0;
      if (strobe.rxStop && !rxSync) errFrame <= 1'b1;
      else if (errClear) errFrame <= 1'b0;
      if (strobe.rxStop && rxValid && !rxRead) errOverrun <= 1'b1;
      else if (errClear) errOverrun <= 1'b0;
    end
  end

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txLoad |=> !serTx); // R2
  AST_RX7_MSB_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rxStop && !cfgChar8) |=> !rxData[CHAR_W-1]); // R8
  AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errParity && !errClear) |=> errParity); // R12
  AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errFrame && !errClear) |=> errFrame); // R12
  AST_RXVALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxRead) |=> rxValid); // R7
endmodule

// File: rtl/async_serial_xcvr.sv
module async_serial_xcvr
  import sxcvr_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgChar8,
  input  logic [1:0]       cfgParity,
  input  logic             cfgStop2,
  input  logic [DIV_W-1:0] cfgDivisor,
  input  logic [7:0]       txData,
  input  logic             txValid,
  output logic             txReady,
  output logic             serTx,
  input  logic             serRx,
  output logic [7:0]       rxData,
  output logic             rxValid,
  input  logic             rxRead,
  output logic             errParity,
  output logic             errFrame,
  output logic             errOverrun,
  input  logic             errClear
);
  strobe_t strobe;
  logic    rxSync;

  sxcvr_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txValid    (txValid),
    .cfgChar8   (cfgChar8),
    .cfgParity  (cfgParity),
    .cfgStop2   (cfgStop2),
    .cfgDivisor (cfgDivisor),
    .rxSync     (rxSync),
    .txReady    (txReady),
    .strobe     (strobe)
  );

  sxcvr_dpath #(.SYNC_STAGES(SYNC_STAGES), .CHAR_W(8)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgChar8   (cfgChar8),
    .cfgParity  (cfgParity),
    .txData     (txData),
    .serRx      (serRx),
    .rxRead     (rxRead),
    .errClear   (errClear),
    .serTx      (serTx),
    .rxSync     (rxSync),
    .rxData     (rxData),
    .rxValid    (rxValid),
    .errParity  (errParity),
    .errFrame   (errFrame),
    .errOverrun (errOverrun)
  );

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> serTx); // R1
endmodule

// File: tb/async_serial_xcvr_tb.sv
module async_serial_xcvr_tb;
  localparam int DIV_W = 16;
  localparam int WATCHDOG = 150000;

  typedef struct packed {
    logic [7:0] div;
    logic       stop2;
    logic [1:0] par;
    logic       char8;
    logic [7:0] data;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{8'd4, 1'b0, 2'd0, 1'b1, 8'hA5},
    '{8'd6, 1'b0, 2'd1, 1'b1, 8'h3C},
    '{8'd5, 1'b1, 2'd2, 1'b0, 8'hD5},
    '{8'd8, 1'b0, 2'd3, 1'b1, 8'h81},
    '{8'd4, 1'b0, 2'd1, 1'b0, 8'hFF},
    '{8'd7, 1'b1, 2'd2, 1'b1, 8'h00}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgChar8 = 1'b1;
  logic [1:0]       cfgParity = 2'd0;
  logic             cfgStop2 = 1'b0;
  logic [DIV_W-1:0] cfgDivisor = 16'd4;
  logic [7:0]       txData = 8'h00;
  logic             txValid = 1'b0;
  logic             txReady;
  logic             serTx;
  logic             serRxIn;
  logic             serRxDrv = 1'b1;
  logic             loopback = 1'b1;
  logic [7:0]       rxData;
  logic             rxValid;
  logic             rxRead = 1'b0;
  logic             errParity;
  logic             errFrame;
  logic             errOverrun;
  logic             errClear = 1'b0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  assign serRxIn = loopback ? serTx : serRxDrv;

  async_serial_xcvr #(.DIV_W(DIV_W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .cfgChar8(cfgChar8), .cfgParity(cfgParity),
    .cfgStop2(cfgStop2), .cfgDivisor(cfgDivisor), .txData(txData),
    .txValid(txValid), .txReady(txReady), .serTx(serTx), .serRx(serRxIn),
    .rxData(rxData), .rxValid(rxValid), .rxRead(rxRead),
    .errParity(errParity), .errFrame(errFrame), .errOverrun(errOverrun),
    .errClear(errClear)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: got %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int frameLen(input vec_t v);
    return 1 + (v.char8 ? 8 : 7) + (v.par != 2'd0 ? 1 : 0) + (v.stop2 ? 2 : 1);
  endfunction

  function automatic logic [11:0] frameBits(input vec_t v);
    logic [11:0] b;
    int pos;
    int nc;
    logic ones;
    b = '1;
    b[0] = 1'b0;
    pos = 1;
    nc = v.char8 ? 8 : 7;
    ones = 1'b0;
    for (int i = 0; i < nc; i++) begin
      b[pos] = v.data[i];
      ones = ones ^ v.data[i];
      pos++;
    end
    if (v.par == 2'd1) b[pos] = ones;
    else if (v.par == 2'd2) b[pos] = ~ones;
    else if (v.par == 2'd3) b[pos] = 1'b0;
    return b;
  endfunction

  task automatic readRx();
    rxRead = 1'b1;
    @(negedge clk);
    rxRead = 1'b0;
  endtask

  task automatic clearErr();
    errClear = 1'b1;
    @(negedge clk);
    errClear = 1'b0;
  endtask

  // loopback transmit/receive of one vector
  task automatic runVector(input vec_t v);
    int d;
    int n;
    int c;
    logic [11:0] got;
    logic [11:0] exp;
    logic [11:0] mask;
    logic [7:0] expRx;
    d = int'(v.div);
    n = frameLen(v);
    exp = frameBits(v);
    mask = (12'd1 << n) - 12'd1;
    expRx = v.char8 ? v.data : (v.data & 8'h7F);
    got = '1;
    @(negedge clk);
    cfgDivisor = DIV_W'(v.div);
    cfgChar8 = v.char8;
    cfgParity = v.par;
    cfgStop2 = v.stop2;
    txData = v.data;
    txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    c = 0;
    while (txReady == 1'b0 && c < 400) begin
      c++;
      if ((c - 1) % d == d / 2 && (c - 1) / d < 12) got[(c - 1) / d] = serTx;
      @(negedge clk);
    end
    // R2 R3 R4: bit sequence on the line
    check(((got ^ exp) & mask) == 12'd0, "R2 R3 R4 frame bits", 32'(got & mask), 32'(exp & mask));
    // R5 R6 R13: busy time equals frame length
    check(c == n * d, "R5 R6 R13 busy cycles", 32'(c), 32'(n * d));
    repeat (2 * d) @(negedge clk);
    // R7 R8: looped character received
    check(rxValid && rxData == expRx, "R7 R8 loopback data", {23'd0, rxValid, rxData}, {23'd0, 1'b1, expRx});
    check({errParity, errFrame, errOverrun} == 3'b000, "R9 R10 R11 no errors",
          32'({errParity, errFrame, errOverrun}), 32'd0);
    readRx();
  endtask

  // bench-driven frame on serRx
  task automatic sendRx(input logic [7:0] d8, input bit char8, input bit hasPar,
                        input bit parVal, input bit stopVal, input int d);
    int nc;
    nc = char8 ? 8 : 7;
    serRxDrv = 1'b0;
    repeat (d) @(negedge clk);
    for (int i = 0; i < nc; i++) begin
      serRxDrv = d8[i];
      repeat (d) @(negedge clk);
    end
    if (hasPar) begin
      serRxDrv = parVal;
      repeat (d) @(negedge clk);
    end
    serRxDrv = stopVal;
    repeat (d) @(negedge clk);
    serRxDrv = 1'b1;
    repeat (2 * d) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(serTx && txReady && !rxValid && !errParity && !errFrame && !errOverrun,
          "R1 reset state", {26'd0, serTx, txReady, rxValid, errParity, errFrame, errOverrun},
          32'b110000);

    for (int i = 0; i < NVEC; i++) runVector(VECS[i]);

    // directed receive tests
    loopback = 1'b0;
    serRxDrv = 1'b1;
    cfgDivisor = 16'd6;
    cfgChar8 = 1'b1;
    cfgParity = 2'd1;
    cfgStop2 = 1'b0;
    repeat (4) @(negedge clk);

    // R7: short glitch ignored
    serRxDrv = 1'b0;
    @(negedge clk);
    serRxDrv = 1'b1;
    repeat (72) @(negedge clk);
    check(!rxValid, "R7 glitch rejected", 32'(rxValid), 32'd0);

    // R9: even parity, 0x0F with parity bit 1 is wrong
    sendRx(8'h0F, 1'b1, 1'b1, 1'b1, 1'b1, 6);
    check(errParity && !errFrame, "R9 even parity error", 32'({errParity, errFrame}), 32'b10);
    check(rxData == 8'h0F, "R7 data with parity error", 32'(rxData), 32'h0F);
    readRx();
    repeat (10) @(negedge clk);
    check(errParity, "R12 flag sticky", 32'(errParity), 32'd1);
    clearErr();
    check(!errParity, "R12 flag cleared", 32'(errParity), 32'd0);

    // R4 R9: zero parity mode, received 1 is an error
    cfgParity = 2'd3;
    sendRx(8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 6);
    check(errParity, "R4 R9 zero parity error", 32'(errParity), 32'd1);
    readRx();
    clearErr();

    // R10: framing error
    cfgParity = 2'd0;
    sendRx(8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 6);
    check(errFrame && !errParity, "R10 framing error", 32'({errFrame, errParity}), 32'b10);
    readRx();
    clearErr();

    // R11: overrun
    sendRx(8'h11, 1'b1, 1'b0, 1'b0, 1'b1, 6);
    sendRx(8'h22, 1'b1, 1'b0, 1'b0, 1'b1, 6);
    check(errOverrun && rxData == 8'h22, "R11 overrun", {23'd0, errOverrun, rxData}, {23'd0, 1'b1, 8'h22});
    readRx();
    clearErr();
    check(!rxValid && !errParity && !errFrame && !errOverrun, "R12 all clear",
          32'({rxValid, errParity, errFrame, errOverrun}), 32'd0);

    // R8: 7-bit frame followed by a high stop bit reads bit 7 as 0
    cfgChar8 = 1'b0;
    sendRx(8'h6B, 1'b0, 1'b0, 1'b0, 1'b1, 6);
    check(rxValid && rxData == 8'h6B, "R8 seven-bit receive", {23'd0, rxValid, rxData}, {23'd0, 1'b1, 8'h6B});
    readRx();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule